// File: doc/BRIEF.md
# Split-Pointer Frame Ring Tracker

This block keeps the pointer bookkeeping for a circular buffer whose unit is a 32-byte frame. The write side has two pointers: the committed pointer marks data a consumer may read, and the allocated pointer marks space already handed out to a producer. The read side also has two pointers: the released (discarded) pointer marks space returned to the producer, and the peeked pointer marks data already handed out to a consumer. Every pointer wraps modulo a power-of-two buffer length. The block holds no data and moves none. A host issues one operation code per cycle. One cycle later the block answers with a grant flag, the buffer offset the operation applies to, and the number of frames granted.

Two styles of transfer are supported. In the multiframe style a producer reserves 16 frames and commits them later, and a consumer peeks 16 frames and releases them later, so a buffer can be in flight between the two steps. In the bulk style a request for any number of frames is clamped to the space that is available and to the end of the buffer, and both pointers of that side move together. A flush realigns the read side to the last multiframe boundary at or below the committed pointer. Four occupancy counts (allocated, valid, unseen, free) are always visible at the ports.

Control is a two-state machine. ST_IDLE means no response is presented. ST_RESP means a registered response is presented. On every clock the machine takes the transition "issue", into ST_RESP, when the operation code is non-zero, and the transition "quiet", into ST_IDLE, when it is zero. This holds from either state, so ST_RESP follows itself for back-to-back operations.

Top module: `frame_ring_tracker`

## Requirements
- R1: After reset all four pointers are zero. cnt_alloc, cnt_valid and cnt_unseen read 0, cnt_free reads LEN_FRAMES-1, and resp_valid is 0.
- R2: op_code encoding: 0 none, 1 reserve, 2 commit, 3 peek, 4 release, 5 bulk write, 6 bulk read, 7 flush. Each non-zero code is answered with resp_valid=1 on the next cycle only. Code 0 gives resp_valid=0 and leaves all pointers unchanged.
- R3: The counts are taken modulo LEN_FRAMES. cnt_valid is committed minus released. cnt_unseen is committed minus peeked. cnt_alloc is allocated minus released. cnt_free is released minus allocated minus 1, so one frame is never usable.
- R4: Reserve is refused (resp_ok=0, resp_frames=0) when cnt_free < 16. Otherwise resp_ok=1 and resp_frames=16, and the allocated pointer advances by 16. In both cases resp_offset is BASE_OFS plus the allocated pointer before the operation.
- R5: Commit advances the committed pointer by 16, and release advances the released pointer by 16. Neither is ever refused: resp_ok=1 and resp_frames=16. resp_offset is BASE_OFS plus the pointer before the advance.
- R6: Peek is refused (resp_ok=0, resp_frames=0) when cnt_unseen < 16. Otherwise resp_ok=1 and resp_frames=16, and the peeked pointer advances by 16. resp_offset is BASE_OFS plus the peeked pointer before the operation.
- R7: Bulk read grants n = min(op_frames, cnt_unseen, LEN_FRAMES - peeked). It sets both read pointers to peeked + n. resp_offset is BASE_OFS plus the old peeked pointer, resp_frames is n, and resp_ok is (n != 0).
- R8: Bulk write grants n = min(op_frames, cnt_free, LEN_FRAMES - committed). It sets both write pointers to committed + n. resp_offset is BASE_OFS plus the old committed pointer, resp_frames is n, and resp_ok is (n != 0).
- R9: Flush sets both read pointers to the committed pointer with its low 4 bits cleared. It answers resp_ok=1 and resp_frames=0, and resp_offset is BASE_OFS plus the new read pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 3 | Operation code (see R2) |
| op_frames | input | PTR_W+1 | Requested frame count for bulk operations |
| resp_valid | output | 1 | Response present (one cycle after an operation) |
| resp_ok | output | 1 | Operation granted |
| resp_offset | output | OFS_W | Buffer offset, in frames, that the operation applies to |
| resp_frames | output | PTR_W+1 | Frames granted |
| cnt_alloc | output | PTR_W | Allocated frame count |
| cnt_valid | output | PTR_W | Valid frame count |
| cnt_unseen | output | PTR_W | Unseen frame count |
| cnt_free | output | PTR_W | Free frame count |

## Verification
On every cycle the assertions check four things. Responses follow operations by exactly one cycle. A reserve or peek is refused exactly when fewer than 16 frames are free or unseen, and a granted reserve grows the allocated count by 16. A bulk grant never exceeds the request or the free or unseen count seen before it. After a flush the read side points at a multiframe boundary, with fewer than 16 unseen frames. The clamp at the buffer end, the wrap of every pointer, and the exact offsets only show up in the bench's scenarios. In those scenarios a reference model of the four pointers predicts every response and count.

// File: rtl/frt_pkg.sv
package frt_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_RESERVE = 3'd1,
        OP_COMMIT  = 3'd2,
        OP_PEEK    = 3'd3,
        OP_RELEASE = 3'd4,
        OP_BULK_WR = 3'd5,
        OP_BULK_RD = 3'd6,
        OP_FLUSH   = 3'd7
    } frt_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } frt_state_e;

    // pointer slots in the bank
    localparam int P_WCOM  = 0;
    localparam int P_WALC  = 1;
    localparam int P_RREL  = 2;
    localparam int P_RPEEK = 3;
    localparam int NUM_PTRS = 4;

endpackage

// File: rtl/frt_ptr_bank.sv
module frt_ptr_bank #(
    parameter int PTR_W = 7,
    parameter int NPTR  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NPTR-1:0]            load,
    input  logic [NPTR-1:0][PTR_W-1:0] next_val,
    output logic [NPTR-1:0][PTR_W-1:0] ptr_q
);
    for (genvar i = 0; i < NPTR; i++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_q[i] <= '0;
            end else if (load[i]) begin
                ptr_q[i] <= next_val[i];
            end
        end
    end
endmodule

// File: rtl/frt_occupancy.sv
module frt_occupancy #(
    parameter int PTR_W = 7
) (
    input  logic [PTR_W-1:0] wcom,
    input  logic [PTR_W-1:0] walc,
    input  logic [PTR_W-1:0] rrel,
    input  logic [PTR_W-1:0] rpeek,
    output logic [PTR_W-1:0] n_alloc,
    output logic [PTR_W-1:0] n_valid,
    output logic [PTR_W-1:0] n_unseen,
    output logic [PTR_W-1:0] n_free
);
    // differences wrap naturally at PTR_W bits (power-of-two length)
    always_comb begin
        n_alloc  = walc - rrel;
        n_valid  = wcom - rrel;
        n_unseen = wcom - rpeek;
        n_free   = rrel - walc - PTR_W'(1);
    end
endmodule

// File: rtl/frt_clamp.sv
module frt_clamp #(
    parameter int W = 8
) (
    input  logic [W-1:0] req,
    input  logic [W-1:0] avail,
    input  logic [W-1:0] to_end,
    output logic [W-1:0] grant
);
    logic [W-1:0] m0;
    always_comb begin
        m0    = (req < avail) ? req : avail;
        grant = (m0 < to_end) ? m0 : to_end;
    end
endmodule

// File: rtl/frame_ring_tracker.sv
module frame_ring_tracker
    import frt_pkg::*;
#(
    parameter int LEN_FRAMES = 128,
    parameter int MF_FRAMES  = 16,
    parameter int BASE_OFS   = 0,
    parameter int OFS_W      = 16,
    localparam int PTR_W     = $clog2(LEN_FRAMES),
    localparam int REQ_W     = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op_code,
    input  logic [REQ_W-1:0] op_frames,
    output logic             resp_valid,
    output logic             resp_ok,
    output logic [OFS_W-1:0] resp_offset,
    output logic [REQ_W-1:0] resp_frames,
    output logic [PTR_W-1:0] cnt_alloc,
    output logic [PTR_W-1:0] cnt_valid,
    output logic [PTR_W-1:0] cnt_unseen,
    output logic [PTR_W-1:0] cnt_free
);
    localparam logic [PTR_W-1:0] MF_P    = PTR_W'(MF_FRAMES);
    localparam logic [REQ_W-1:0] MF_R    = REQ_W'(MF_FRAMES);
    localparam logic [REQ_W-1:0] LEN_R   = REQ_W'(LEN_FRAMES);
    localparam logic [PTR_W-1:0] ALN_MSK = ~PTR_W'(MF_FRAMES - 1);

    frt_op_e    op;
    frt_state_e state_q, state_d;

    logic [NUM_PTRS-1:0]            ld;
    logic [NUM_PTRS-1:0][PTR_W-1:0] nxt;
    logic [NUM_PTRS-1:0][PTR_W-1:0] ptr;

    logic [PTR_W-1:0] n_alloc, n_valid, n_unseen, n_free;
    logic [REQ_W-1:0] wr_grant, rd_grant;
    logic [PTR_W-1:0] flush_ptr;

    logic             ok_d;
    logic [PTR_W-1:0] ofs_ptr_d;
    logic [REQ_W-1:0] frames_d;

    assign op = frt_op_e'(op_code);

    frt_ptr_bank #(.PTR_W(PTR_W), .NPTR(NUM_PTRS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .next_val (nxt),
        .ptr_q    (ptr)
    );

    frt_occupancy #(.PTR_W(PTR_W)) u_occ (
        .wcom     (ptr[P_WCOM]),
        .walc     (ptr[P_WALC]),
        .rrel     (ptr[P_RREL]),
        .rpeek    (ptr[P_RPEEK]),
        .n_alloc  (n_alloc),
        .n_valid  (n_valid),
        .n_unseen (n_unseen),
        .n_free   (n_free)
    );

    frt_clamp #(.W(REQ_W)) u_clamp_wr (
        .req    (op_frames),
        .avail  ({1'b0, n_free}),
        .to_end (LEN_R - {1'b0, ptr[P_WCOM]}),
        .grant  (wr_grant)
    );

    frt_clamp #(.W(REQ_W)) u_clamp_rd (
        .req    (op_frames),
        .avail  ({1'b0, n_unseen}),
        .to_end (LEN_R - {1'b0, ptr[P_RPEEK]}),
        .grant  (rd_grant)
    );

    assign flush_ptr = ptr[P_WCOM] & ALN_MSK;

    // operation decode: pointer updates and response contents
    always_comb begin
        ld        = '0;
        nxt       = ptr;
        ok_d      = 1'b0;
        ofs_ptr_d = ptr[P_WCOM];
        frames_d  = '0;
        unique case (op)
            OP_NONE: begin
            end
            OP_RESERVE: begin
                ofs_ptr_d = ptr[P_WALC];
                if (n_free >= MF_P) begin
                    ok_d         = 1'b1;
                    frames_d     = MF_R;
                    ld[P_WALC]   = 1'b1;
                    nxt[P_WALC]  = ptr[P_WALC] + MF_P;
                end
            end
            OP_COMMIT: begin
                ofs_ptr_d    = ptr[P_WCOM];
                ok_d         = 1'b1;
                frames_d     = MF_R;
                ld[P_WCOM]   = 1'b1;
                nxt[P_WCOM]  = ptr[P_WCOM] + MF_P;
            end
            OP_PEEK: begin
                ofs_ptr_d = ptr[P_RPEEK];
                if (n_unseen >= MF_P) begin
                    ok_d          = 1'b1;
                    frames_d      = MF_R;
                    ld[P_RPEEK]   = 1'b1;
                    nxt[P_RPEEK]  = ptr[P_RPEEK] + MF_P;
                end
            end
            OP_RELEASE: begin
                ofs_ptr_d    = ptr[P_RREL];
                ok_d         = 1'b1;
                frames_d     = MF_R;
                ld[P_RREL]   = 1'b1;
                nxt[P_RREL]  = ptr[P_RREL] + MF_P;
            end
            OP_BULK_WR: begin
                ofs_ptr_d    = ptr[P_WCOM];
                frames_d     = wr_grant;
                ok_d         = (wr_grant != '0);
                ld[P_WCOM]   = 1'b1;
                ld[P_WALC]   = 1'b1;
                nxt[P_WCOM]  = ptr[P_WCOM] + wr_grant[PTR_W-1:0];
                nxt[P_WALC]  = ptr[P_WCOM] + wr_grant[PTR_W-1:0];
            end
            OP_BULK_RD: begin
                ofs_ptr_d     = ptr[P_RPEEK];
                frames_d      = rd_grant;
                ok_d          = (rd_grant != '0);
                ld[P_RPEEK]   = 1'b1;
                ld[P_RREL]    = 1'b1;
                nxt[P_RPEEK]  = ptr[P_RPEEK] + rd_grant[PTR_W-1:0];
                nxt[P_RREL]   = ptr[P_RPEEK] + rd_grant[PTR_W-1:0];
            end
            OP_FLUSH: begin
                ofs_ptr_d     = flush_ptr;
                ok_d          = 1'b1;
                ld[P_RPEEK]   = 1'b1;
                ld[P_RREL]    = 1'b1;
                nxt[P_RPEEK]  = flush_ptr;
                nxt[P_RREL]   = flush_ptr;
            end
            default: begin
            end
        endcase
    end

    // next state: issue -> ST_RESP, quiet -> ST_IDLE
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = (op != OP_NONE) ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = (op != OP_NONE) ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_ok     <= 1'b0;
            resp_offset <= '0;
            resp_frames <= '0;
        end else if (op != OP_NONE) begin
            resp_ok     <= ok_d;
            resp_offset <= OFS_W'(BASE_OFS) + OFS_W'(ofs_ptr_d);
            resp_frames <= frames_d;
        end
    end

    assign resp_valid = (state_q == ST_RESP);
    assign cnt_alloc  = n_alloc;
    assign cnt_valid  = n_valid;
    assign cnt_unseen = n_unseen;
    assign cnt_free   = n_free;

endmodule

// File: rtl/frame_ring_tracker_chk.sv
module frame_ring_tracker_chk #(
    parameter int PTR_W     = 7,
    parameter int REQ_W     = 8,
    parameter int OFS_W     = 16,
    parameter int MF_FRAMES = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       op_code,
    input logic [REQ_W-1:0] op_frames,
    input logic             resp_valid,
    input logic             resp_ok,
    input logic [OFS_W-1:0] resp_offset,
    input logic [REQ_W-1:0] resp_frames,
    input logic [PTR_W-1:0] cnt_alloc,
    input logic [PTR_W-1:0] cnt_valid,
    input logic [PTR_W-1:0] cnt_unseen,
    input logic [PTR_W-1:0] cnt_free
);
    localparam logic [PTR_W-1:0] MF_P = PTR_W'(MF_FRAMES);

    logic unused_ok;
    assign unused_ok = ^resp_offset;

    p_resp_follows_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code != 3'd0) |=> resp_valid);

    p_no_resp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd0) |=> !resp_valid);

    p_reserve_deny_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd1 && cnt_free < MF_P) |=> (!resp_ok && resp_frames == '0));

    p_reserve_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd1 && cnt_free >= MF_P) |=>
            (resp_ok && cnt_alloc == PTR_W'($past(cnt_alloc) + MF_P)));

    p_peek_deny_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd3 && cnt_unseen < MF_P) |=> (!resp_ok && resp_frames == '0));

    p_peek_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd3 && cnt_unseen >= MF_P) |=>
            (resp_ok && cnt_unseen == PTR_W'($past(cnt_unseen) - MF_P)));

    p_bulk_rd_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd6) |=>
            (resp_frames <= $past(op_frames) && resp_frames <= {1'b0, $past(cnt_unseen)}));

    p_bulk_wr_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd5) |=>
            (resp_frames <= $past(op_frames) && resp_frames <= {1'b0, $past(cnt_free)}));

    p_flush_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd7) |=>
            (cnt_valid == cnt_unseen && cnt_unseen < MF_P && resp_ok));

endmodule

bind frame_ring_tracker frame_ring_tracker_chk #(
    .PTR_W     (PTR_W),
    .REQ_W     (REQ_W),
    .OFS_W     (OFS_W),
    .MF_FRAMES (MF_FRAMES)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_code     (op_code),
    .op_frames   (op_frames),
    .resp_valid  (resp_valid),
    .resp_ok     (resp_ok),
    .resp_offset (resp_offset),
    .resp_frames (resp_frames),
    .cnt_alloc   (cnt_alloc),
    .cnt_valid   (cnt_valid),
    .cnt_unseen  (cnt_unseen),
    .cnt_free    (cnt_free)
);

// File: tb/frame_ring_tracker_tb_top.sv
module frame_ring_tracker_tb_top;
    localparam int LEN   = 128;
    localparam int MF    = 16;
    localparam int BASE  = 'h300;
    localparam int OFSW  = 16;
    localparam int PW    = $clog2(LEN);
    localparam int RW    = PW + 1;
    localparam int MASK  = LEN - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    op_code = 3'd0;
    logic [RW-1:0] op_frames = '0;
    logic          resp_valid, resp_ok;
    logic [OFSW-1:0] resp_offset;
    logic [RW-1:0] resp_frames;
    logic [PW-1:0] cnt_alloc, cnt_valid, cnt_unseen, cnt_free;

    always #2.5 clk = ~clk;

    frame_ring_tracker #(
        .LEN_FRAMES (LEN),
        .MF_FRAMES  (MF),
        .BASE_OFS   (BASE),
        .OFS_W      (OFSW)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_code     (op_code),
        .op_frames   (op_frames),
        .resp_valid  (resp_valid),
        .resp_ok     (resp_ok),
        .resp_offset (resp_offset),
        .resp_frames (resp_frames),
        .cnt_alloc   (cnt_alloc),
        .cnt_valid   (cnt_valid),
        .cnt_unseen  (cnt_unseen),
        .cnt_free    (cnt_free)
    );

    typedef struct {
        string tag;
        bit    has_resp;
        bit    ok;
        int    ofs;
        int    frames;
        int    alloc;
        int    valid;
        int    unseen;
        int    free;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   run_done = 1'b0;

    // reference pointers
    int m_wc = 0, m_wa = 0, m_rd = 0, m_rp = 0;

    function automatic int imin(int a, int b);
        return (a < b) ? a : b;
    endfunction

    task automatic chk(string tag, string what, int act, int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // driver: apply one op, predict its response, push to scoreboard
    task automatic do_op(int code, int req);
        exp_t e;
        int free_n, unseen_n, n;
        @(negedge clk);
        op_code   = code[2:0];
        op_frames = req[RW-1:0];
        free_n    = (m_rd - m_wa - 1) & MASK;
        unseen_n  = (m_wc - m_rp) & MASK;
        e.has_resp = (code != 0);
        e.ok = 1'b0; e.frames = 0; e.ofs = 0;
        case (code)
            1: begin
                e.tag = "R4"; e.ofs = BASE + m_wa;
                if (free_n >= MF) begin e.ok = 1; e.frames = MF; m_wa = (m_wa + MF) & MASK; end
            end
            2: begin e.tag = "R5"; e.ofs = BASE + m_wc; e.ok = 1; e.frames = MF; m_wc = (m_wc + MF) & MASK; end
            3: begin
                e.tag = "R6"; e.ofs = BASE + m_rp;
                if (unseen_n >= MF) begin e.ok = 1; e.frames = MF; m_rp = (m_rp + MF) & MASK; end
            end
            4: begin e.tag = "R5"; e.ofs = BASE + m_rd; e.ok = 1; e.frames = MF; m_rd = (m_rd + MF) & MASK; end
            5: begin
                e.tag = "R8"; e.ofs = BASE + m_wc;
                n = imin(imin(req, free_n), LEN - m_wc);
                e.frames = n; e.ok = (n != 0);
                m_wc = (m_wc + n) & MASK; m_wa = m_wc;
            end
            6: begin
                e.tag = "R7"; e.ofs = BASE + m_rp;
                n = imin(imin(req, unseen_n), LEN - m_rp);
                e.frames = n; e.ok = (n != 0);
                m_rp = (m_rp + n) & MASK; m_rd = m_rp;
            end
            7: begin
                e.tag = "R9"; m_rp = m_wc & ~(MF - 1); m_rd = m_rp;
                e.ofs = BASE + m_rp; e.ok = 1;
            end
            default: e.tag = "R2";
        endcase
        e.alloc  = (m_wa - m_rd) & MASK;
        e.valid  = (m_wc - m_rd) & MASK;
        e.unseen = (m_wc - m_rp) & MASK;
        e.free   = (m_rd - m_wa - 1) & MASK;
        exp_q.push_back(e);
    endtask

    // monitor: one cycle after each op, compare with the scoreboard
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                chk("R2", {e.tag, " resp_valid"}, int'(resp_valid), int'(e.has_resp));
                if (e.has_resp) begin
                    chk(e.tag, "resp_ok", int'(resp_ok), int'(e.ok));
                    chk(e.tag, "resp_offset", int'(resp_offset), e.ofs);
                    chk(e.tag, "resp_frames", int'(resp_frames), e.frames);
                end
                chk("R3", {e.tag, " cnt_alloc"},  int'(cnt_alloc),  e.alloc);
                chk("R3", {e.tag, " cnt_valid"},  int'(cnt_valid),  e.valid);
                chk("R3", {e.tag, " cnt_unseen"}, int'(cnt_unseen), e.unseen);
                chk("R3", {e.tag, " cnt_free"},   int'(cnt_free),   e.free);
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!run_done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", "resp_valid", int'(resp_valid), 0);
        chk("R1", "cnt_alloc",  int'(cnt_alloc), 0);
        chk("R1", "cnt_valid",  int'(cnt_valid), 0);
        chk("R1", "cnt_unseen", int'(cnt_unseen), 0);
        chk("R1", "cnt_free",   int'(cnt_free), LEN - 1);

        // R4: reserve until refused (free 127 -> 7 grants, then 15 free)
        for (int i = 0; i < 8; i++) do_op(1, 0);
        // R6: peek with nothing committed is refused
        do_op(3, 0);
        // R5: two commits, R6: two peeks granted, third refused
        do_op(2, 0); do_op(2, 0);
        do_op(3, 0); do_op(3, 0); do_op(3, 0);
        // R5: release one multiframe
        do_op(4, 0);
        // R2: idle cycle leaves everything unchanged
        do_op(0, 5);
        // R7: bulk read with nothing unseen grants zero
        do_op(6, 10);
        // commit remaining reservations, then bulk read clamped by unseen
        for (int i = 0; i < 5; i++) do_op(2, 0);
        do_op(6, 100);
        // R8: bulk write clamped at the buffer end (wraps to 0)
        do_op(5, 50);
        // R4: reserve after wrap starts at offset base+0
        do_op(1, 0);
        do_op(2, 0);
        // R9: flush on an aligned committed pointer
        do_op(7, 0);
        do_op(6, 5);
        // R8: unaligned bulk write, R9: flush rounds down, R7: full request clamped
        do_op(5, 3);
        do_op(7, 0);
        do_op(6, LEN);
        // R8: bulk write limited by free space
        do_op(5, 120);
        do_op(5, 120);
        do_op(0, 0);
        @(negedge clk);
        op_code = 3'd0;
        while (exp_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        run_done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule